// File: doc/BRIEF.md
# Predicated Multi-Lane Vector Arithmetic Unit

This block runs element-wise vector arithmetic over a banked vector register file that it owns. A decoded instruction (operation code, destination and two source register numbers, a predicate enable and a small immediate) comes in on a valid/ready handshake. The unit walks the active vector length through `LANES` parallel lanes, one element per lane per cycle, and writes each result back into the destination register. Element `e` lives in bank `e mod LANES` at row `e / LANES`. Only the first `MUL_LANES` lanes have a multiplier, so a multiply walks the vector in narrower steps.

The vector length is a register inside the unit, and it is set by an instruction. Results cover add and subtract (wrapping), signed min and max, saturating absolute value, saturating add and subtract, arithmetic right shift and multiply. Any saturation raises a sticky flag. When predication is on, bit 0 of element `e` of register 0 decides whether element `e` of the destination is written. Register contents reach the block through a plain element load port. They leave it through a combinational readback port.

Handshake rule: `in_ready` is high exactly when the unit is idle (`done` high). An instruction is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_valid` is ignored while the unit is busy, and the producer holds the instruction until it is taken.

Top module: `vxu_top`

## Requirements
- R1: Operation code 9 sets the vector length to the immediate, clamped to MVL (16 by default), with no busy cycles. Arithmetic writes only elements below the vector length, and elements at or above it keep their value. A vector length of 0 gives zero busy cycles and no writes.
- R2: Codes 0 (add), 1 (subtract), 2 (signed min) and 3 (signed max) produce, for each element, the W-bit result of operand A against operand B. Add and subtract wrap modulo 2^W.
- R3: Code 4 writes the absolute value of operand A. The most negative value saturates to the largest positive value and sets the saturation flag.
- R4: Codes 5 (add) and 6 (subtract) saturate. On signed overflow the result clamps to the W-bit signed maximum or minimum, and the saturation flag is set.
- R5: Code 7 shifts operand A right arithmetically by the low log2(W) bits of operand B.
- R6: Code 8 writes the low W bits of the signed product. It keeps the unit busy for ceil(VL/MUL_LANES) cycles.
- R7: Codes 0 to 7 keep the unit busy (`done` low) for exactly ceil(VL/LANES) cycles after the accepting edge.
- R8: While `done` is low, `in_valid` has no effect: an instruction presented then is neither executed nor queued. `in_ready` equals `done`.
- R9: The saturation flag stays set until code 10 is accepted, which clears it.
- R10: With `in_masked` high, an element whose register-0 element has bit 0 clear keeps its old destination value.
- R11: `ld_en` writes `ld_data` into element `ld_elem` of register `ld_reg` when the unit is idle, and has no effect while it is busy. `rb_data` shows element `rb_elem` of register `rb_reg` combinationally.
- R12: After reset, `done` is 1, the saturation flag is 0, the vector length is MVL and every register element is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction can be taken (unit idle) |
| in_op | input | 4 | Operation code |
| in_vd | input | log2(NREG) | Destination register |
| in_va | input | log2(NREG) | Source register A |
| in_vb | input | log2(NREG) | Source register B |
| in_masked | input | 1 | Predicate on register 0 bit 0 |
| in_imm | input | log2(MVL)+1 | Vector-length immediate |
| ld_en | input | 1 | Element load strobe |
| ld_reg | input | log2(NREG) | Load register |
| ld_elem | input | log2(MVL) | Load element index |
| ld_data | input | W | Load value |
| rb_reg | input | log2(NREG) | Readback register |
| rb_elem | input | log2(MVL) | Readback element index |
| rb_data | output | W | Readback value |
| done | output | 1 | Whole vector processed, unit idle |
| cur_vl | output | log2(MVL)+1 | Current vector length |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
The hardest situation to create is a multiply whose lane group rotates across the banks. Here the multiplier in lane j has to take operands from bank (beat·MUL_LANES mod LANES)+j and write its result back there. A partial vector length that ends inside such a group adds to the difficulty. The stimulus runs multiplies at full length and at length 5, so the final group is cut short, and compares every destination element against a model. While a multiply is still busy, the bench also offers a competing instruction and an element load. It then checks through the readback port that neither one left a trace.

// File: rtl/vxu_pkg.sv
package vxu_pkg;
  typedef enum logic [3:0] {
    OP_ADD    = 4'd0,
    OP_SUB    = 4'd1,
    OP_MIN    = 4'd2,
    OP_MAX    = 4'd3,
    OP_ABS    = 4'd4,
    OP_SADD   = 4'd5,
    OP_SSUB   = 4'd6,
    OP_SRA    = 4'd7,
    OP_MUL    = 4'd8,
    OP_SETVL  = 4'd9,
    OP_CLRSAT = 4'd10
  } vop_e;
endpackage

// File: rtl/vxu_bank.sv
module vxu_bank #(
  parameter int W    = 16,
  parameter int NREG = 8,
  parameter int ROWS = 4,
  parameter int RGW  = 3,
  parameter int RW   = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [RGW-1:0] ra_reg,
  input  logic [RGW-1:0] rb_reg,
  input  logic [RGW-1:0] rx_reg,
  input  logic [RW-1:0]  row,
  input  logic [RW-1:0]  rx_row,
  output logic [W-1:0]   ra_data,
  output logic [W-1:0]   rb_data,
  output logic           mask_bit,
  output logic [W-1:0]   rx_data,
  input  logic           we,
  input  logic [RGW-1:0] wreg,
  input  logic [RW-1:0]  wrow,
  input  logic [W-1:0]   wdata
);
  logic [W-1:0] mem [NREG][ROWS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++)
        for (int c = 0; c < ROWS; c++)
          mem[r][c] <= '0;
    end else if (we) begin
      mem[wreg][wrow] <= wdata;
    end
  end

  assign ra_data  = mem[ra_reg][row];
  assign rb_data  = mem[rb_reg][row];
  assign mask_bit = mem[0][row][0];
  assign rx_data  = mem[rx_reg][rx_row];
endmodule

// File: rtl/vxu_alu.sv
module vxu_alu
  import vxu_pkg::*;
#(
  parameter int W = 16
) (
  input  vop_e         op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         sat
);
  localparam int SHW = (W > 1) ? $clog2(W) : 1;
  localparam logic [W-1:0] MINV = W'(1) << (W - 1);
  localparam logic [W-1:0] MAXV = ~MINV;

  logic [W:0] sum, dif;
  logic       sum_ovf, dif_ovf;

  assign sum     = {a[W-1], a} + {b[W-1], b};
  assign dif     = {a[W-1], a} - {b[W-1], b};
  assign sum_ovf = sum[W] ^ sum[W-1];
  assign dif_ovf = dif[W] ^ dif[W-1];

  always_comb begin
    res = a;
    sat = 1'b0;
    unique case (op)
      OP_ADD: res = sum[W-1:0];
      OP_SUB: res = dif[W-1:0];
      OP_MIN: res = ($signed(a) < $signed(b)) ? a : b;
      OP_MAX: res = ($signed(a) > $signed(b)) ? a : b;
      OP_ABS: begin
        if (a == MINV) begin
          res = MAXV;
          sat = 1'b1;
        end else if (a[W-1]) begin
          res = -a;
        end
      end
      OP_SADD: begin
        res = sum_ovf ? (sum[W] ? MINV : MAXV) : sum[W-1:0];
        sat = sum_ovf;
      end
      OP_SSUB: begin
        res = dif_ovf ? (dif[W] ? MINV : MAXV) : dif[W-1:0];
        sat = dif_ovf;
      end
      OP_SRA: res = $unsigned($signed(a) >>> b[SHW-1:0]);
      default: res = a;
    endcase
  end
endmodule

// File: rtl/vxu_mul.sv
module vxu_mul #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);
  // low W bits of a two's-complement product equal those of the unsigned one
  assign res = a * b;
endmodule

// File: rtl/vxu_seq.sv
module vxu_seq
  import vxu_pkg::*;
#(
  parameter int          LANES     = 4,
  parameter int          MUL_LANES = 2,
  parameter int          MVL       = 16,
  parameter int          RGW       = 3,
  parameter int          VLW       = 5,
  parameter int          IW        = 6,
  parameter logic [15:0] OP_EN     = 16'hFFFF
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [3:0]     in_op,
  input  logic [RGW-1:0] in_vd,
  input  logic [RGW-1:0] in_va,
  input  logic [RGW-1:0] in_vb,
  input  logic           in_masked,
  input  logic [VLW-1:0] in_imm,
  input  logic           sat_set,
  output logic           busy,
  output logic [IW-1:0]  beat,
  output logic [VLW-1:0] vl,
  output vop_e           op_q,
  output logic [RGW-1:0] vd_q,
  output logic [RGW-1:0] va_q,
  output logic [RGW-1:0] vb_q,
  output logic           masked_q,
  output logic           sat
);
  localparam int LOG_L = $clog2(LANES);
  localparam int LOG_X = $clog2(MUL_LANES);

  vop_e          op_in;
  logic          accept, enabled, is_arith;
  logic [IW-1:0] vl_ext, alu_beats, mul_beats, beats_sel, nb_q;

  assign op_in     = vop_e'(in_op);
  assign accept    = in_valid && !busy;
  assign enabled   = OP_EN[in_op];
  assign is_arith  = (in_op <= 4'd8);
  assign vl_ext    = IW'(vl);
  assign alu_beats = (vl_ext + IW'(LANES - 1)) >> LOG_L;
  assign mul_beats = (vl_ext + IW'(MUL_LANES - 1)) >> LOG_X;
  assign beats_sel = (op_in == OP_MUL) ? mul_beats : alu_beats;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      beat     <= '0;
      nb_q     <= '0;
      vl       <= VLW'(MVL);
      op_q     <= OP_ADD;
      vd_q     <= '0;
      va_q     <= '0;
      vb_q     <= '0;
      masked_q <= 1'b0;
      sat      <= 1'b0;
    end else begin
      if (busy) begin
        if (sat_set) sat <= 1'b1;
        beat <= beat + IW'(1);
        if (beat == nb_q - IW'(1)) busy <= 1'b0;
      end else if (accept && enabled) begin
        if (op_in == OP_SETVL) begin
          vl <= (in_imm > VLW'(MVL)) ? VLW'(MVL) : in_imm;
        end else if (op_in == OP_CLRSAT) begin
          sat <= 1'b0;
        end else if (is_arith && beats_sel != '0) begin
          busy     <= 1'b1;
          beat     <= '0;
          nb_q     <= beats_sel;
          op_q     <= op_in;
          vd_q     <= in_vd;
          va_q     <= in_va;
          vb_q     <= in_vb;
          masked_q <= in_masked;
        end
      end
    end
  end
endmodule

// File: rtl/vxu_top.sv
module vxu_top
  import vxu_pkg::*;
#(
  parameter int          LANES     = 4,
  parameter int          MUL_LANES = 2,
  parameter int          MVL       = 16,
  parameter int          W         = 16,
  parameter int          NREG      = 8,
  parameter logic [15:0] OP_EN     = 16'hFFFF,
  localparam int         EW        = $clog2(MVL),
  localparam int         VLW       = EW + 1,
  localparam int         RGW       = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [3:0]     in_op,
  input  logic [RGW-1:0] in_vd,
  input  logic [RGW-1:0] in_va,
  input  logic [RGW-1:0] in_vb,
  input  logic           in_masked,
  input  logic [VLW-1:0] in_imm,
  input  logic           ld_en,
  input  logic [RGW-1:0] ld_reg,
  input  logic [EW-1:0]  ld_elem,
  input  logic [W-1:0]   ld_data,
  input  logic [RGW-1:0] rb_reg,
  input  logic [EW-1:0]  rb_elem,
  output logic [W-1:0]   rb_data,
  output logic           done,
  output logic [VLW-1:0] cur_vl,
  output logic           sat_flag
);
  localparam int LOG_L = $clog2(LANES);
  localparam int LOG_X = $clog2(MUL_LANES);
  localparam int ROWS  = MVL / LANES;
  localparam int RW    = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int IW    = EW + 2;

  logic           busy, masked_q, sat_set, mul_mode;
  logic [IW-1:0]  beat, mul_base, grp, row_full;
  logic [RW-1:0]  row, ld_row, rb_row;
  logic [VLW-1:0] vl;
  vop_e           op_q;
  logic [RGW-1:0] vd_q, va_q, vb_q;

  logic [W-1:0] a_rd   [LANES];
  logic [W-1:0] b_rd   [LANES];
  logic [W-1:0] x_rd   [LANES];
  logic [W-1:0] alu_rs [LANES];
  logic [W-1:0] wr_res [LANES];
  logic [W-1:0] m_a    [MUL_LANES];
  logic [W-1:0] m_b    [MUL_LANES];
  logic [W-1:0] m_rs   [MUL_LANES];
  logic [LANES-1:0] m_bit, act, alu_sat;

  vxu_seq #(
    .LANES(LANES), .MUL_LANES(MUL_LANES), .MVL(MVL), .RGW(RGW),
    .VLW(VLW), .IW(IW), .OP_EN(OP_EN)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_vd(in_vd), .in_va(in_va), .in_vb(in_vb), .in_masked(in_masked),
    .in_imm(in_imm), .sat_set(sat_set), .busy(busy), .beat(beat), .vl(vl),
    .op_q(op_q), .vd_q(vd_q), .va_q(va_q), .vb_q(vb_q),
    .masked_q(masked_q), .sat(sat_flag)
  );

  // all banks share one row per beat; a multiply group is a slice of banks
  assign mul_mode = (op_q == OP_MUL);
  assign mul_base = beat << LOG_X;
  assign grp      = mul_base & IW'(LANES - 1);
  assign row_full = mul_mode ? (mul_base >> LOG_L) : beat;
  assign row      = RW'(row_full);
  assign ld_row   = RW'(ld_elem >> LOG_L);
  assign rb_row   = RW'(rb_elem >> LOG_L);

  genvar k;
  generate
    for (k = 0; k < LANES; k++) begin : g_lane
      logic [IW-1:0]  elem_k;
      logic           in_grp, mask_ok, ld_hit, we_k;
      logic [RGW-1:0] wreg_k;
      logic [RW-1:0]  wrow_k;
      logic [W-1:0]   wdat_k;

      assign elem_k  = (row_full << LOG_L) + IW'(k);
      assign in_grp  = !mul_mode ||
                       ((IW'(k) >= grp) && (IW'(k) < grp + IW'(MUL_LANES)));
      assign mask_ok = !masked_q || m_bit[k];
      assign act[k]  = busy && (elem_k < IW'(vl)) && in_grp && mask_ok;
      assign ld_hit  = ld_en && ((IW'(ld_elem) & IW'(LANES - 1)) == IW'(k));
      assign we_k    = busy ? act[k] : ld_hit;
      assign wreg_k  = busy ? vd_q : ld_reg;
      assign wrow_k  = busy ? row : ld_row;
      assign wdat_k  = busy ? wr_res[k] : ld_data;

      vxu_bank #(
        .W(W), .NREG(NREG), .ROWS(ROWS), .RGW(RGW), .RW(RW)
      ) bank_i (
        .clk(clk), .rst_n(rst_n), .ra_reg(va_q), .rb_reg(vb_q),
        .rx_reg(rb_reg), .row(row), .rx_row(rb_row), .ra_data(a_rd[k]),
        .rb_data(b_rd[k]), .mask_bit(m_bit[k]), .rx_data(x_rd[k]),
        .we(we_k), .wreg(wreg_k), .wrow(wrow_k), .wdata(wdat_k)
      );

      vxu_alu #(.W(W)) alu_i (
        .op(op_q), .a(a_rd[k]), .b(b_rd[k]), .res(alu_rs[k]),
        .sat(alu_sat[k])
      );
    end

    for (k = 0; k < MUL_LANES; k++) begin : g_mul
      vxu_mul #(.W(W)) mul_i (.a(m_a[k]), .b(m_b[k]), .res(m_rs[k]));
    end
  endgenerate

  // route bank operands to multipliers and products back to banks
  always_comb begin
    for (int j = 0; j < MUL_LANES; j++) begin
      m_a[j] = '0;
      m_b[j] = '0;
      for (int i = 0; i < LANES; i++) begin
        if (IW'(i) == grp + IW'(j)) begin
          m_a[j] = a_rd[i];
          m_b[j] = b_rd[i];
        end
      end
    end
    for (int i = 0; i < LANES; i++) begin
      wr_res[i] = alu_rs[i];
      if (mul_mode) begin
        for (int j = 0; j < MUL_LANES; j++)
          if (IW'(i) == grp + IW'(j)) wr_res[i] = m_rs[j];
      end
    end
  end

  always_comb begin
    rb_data = '0;
    for (int i = 0; i < LANES; i++)
      if ((IW'(rb_elem) & IW'(LANES - 1)) == IW'(i)) rb_data = x_rd[i];
  end

  assign sat_set  = busy && !mul_mode && |(act & alu_sat);
  assign done     = !busy;
  assign in_ready = !busy;
  assign cur_vl   = vl;
endmodule

// File: rtl/vxu_chk.sv
module vxu_chk #(
  parameter int          MVL   = 16,
  parameter int          VLW   = 5,
  parameter logic [15:0] OP_EN = 16'hFFFF
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic [3:0]     in_op,
  input logic [VLW-1:0] in_imm,
  input logic           done,
  input logic [VLW-1:0] cur_vl,
  input logic           sat_flag
);
  int unsigned busy_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) busy_cnt <= 0;
    else if (done) busy_cnt <= 0;
    else busy_cnt <= busy_cnt + 1;
  end

  a_r1_vl_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cur_vl <= VLW'(MVL));

  a_r1_setvl: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op == 4'd9 && OP_EN[9]) |=>
      cur_vl == (($past(in_imm) > VLW'(MVL)) ? VLW'(MVL) : $past(in_imm)));

  a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op <= 4'd8 && OP_EN[in_op] && cur_vl != '0)
      |=> !done);

  a_r7_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= MVL);

  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !in_valid) |=> done);

  a_r9_sat_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_flag && !(in_valid && in_ready && in_op == 4'd10)) |=> sat_flag);

  a_r9_sat_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op == 4'd10 && OP_EN[10]) |=> !sat_flag);
endmodule

bind vxu_top vxu_chk #(.MVL(MVL), .VLW(VLW), .OP_EN(OP_EN)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_imm(in_imm), .done(done), .cur_vl(cur_vl),
  .sat_flag(sat_flag)
);

// File: tb/vxu_top_tb_top.sv
module vxu_top_tb_top;
  localparam int L = 4, X = 2, MVL = 16, NR = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_masked = 1'b0, ld_en = 1'b0;
  logic        in_ready, done, sat_flag;
  logic [3:0]  in_op = '0;
  logic [2:0]  in_vd = '0, in_va = '0, in_vb = '0, ld_reg = '0, rb_reg = '0;
  logic [4:0]  in_imm = '0, cur_vl;
  logic [3:0]  ld_elem = '0, rb_elem = '0;
  logic [15:0] ld_data = '0, rb_data;

  always #10 clk = ~clk;

  vxu_top dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_vd(in_vd), .in_va(in_va), .in_vb(in_vb),
    .in_masked(in_masked), .in_imm(in_imm), .ld_en(ld_en), .ld_reg(ld_reg),
    .ld_elem(ld_elem), .ld_data(ld_data), .rb_reg(rb_reg),
    .rb_elem(rb_elem), .rb_data(rb_data), .done(done), .cur_vl(cur_vl),
    .sat_flag(sat_flag)
  );

  typedef struct { int r; int e; logic [15:0] v; string tag; } exp_t;
  exp_t        sb[$];
  logic [15:0] mdl [NR][MVL];
  int          mvl_now = MVL;
  bit          msat = 1'b0;
  int          n_chk = 0, n_bad = 0;
  bit          finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] model_op(input int op, input logic [15:0] a,
                                           input logic [15:0] b, output bit s);
    int sa, sb_, r;
    sa = int'($signed(a));
    sb_ = int'($signed(b));
    s = 1'b0;
    r = sa;
    case (op)
      0: r = sa + sb_;
      1: r = sa - sb_;
      2: r = (sa < sb_) ? sa : sb_;
      3: r = (sa > sb_) ? sa : sb_;
      4: begin
        r = (sa < 0) ? -sa : sa;
        if (r > 32767) begin r = 32767; s = 1'b1; end
      end
      5, 6: begin
        r = (op == 5) ? sa + sb_ : sa - sb_;
        if (r > 32767) begin r = 32767; s = 1'b1; end
        if (r < -32768) begin r = -32768; s = 1'b1; end
      end
      7: r = sa >>> (b & 16'hF);
      8: r = sa * sb_;
      default: r = sa;
    endcase
    return r[15:0];
  endfunction

  // driver: present one instruction, update the model, count busy cycles
  task automatic issue(input int op, input int vd, input int va, input int vb,
                       input bit msk, input int imm, input string tag);
    int cyc, expc;
    bit s;
    logic [15:0] nv;
    @(negedge clk);
    in_valid = 1'b1; in_op = 4'(op); in_vd = 3'(vd); in_va = 3'(va);
    in_vb = 3'(vb); in_masked = msk; in_imm = 5'(imm);
    @(negedge clk);
    in_valid = 1'b0;
    cyc = 0;
    while (!done && cyc < 100) begin cyc++; @(negedge clk); end
    if (op == 9) mvl_now = (imm > MVL) ? MVL : imm;
    if (op == 10) msat = 1'b0;
    if (op <= 8) begin
      for (int e = 0; e < mvl_now; e++) begin
        nv = model_op(op, mdl[va][e], mdl[vb][e], s);
        if (!msk || mdl[0][e][0]) begin
          mdl[vd][e] = nv;
          if (s && op != 8) msat = 1'b1;
        end
      end
      expc = (op == 8) ? (mvl_now + X - 1) / X : (mvl_now + L - 1) / L;
      chk(cyc == expc, {tag, " R7 R6 busy cycles"}, cyc, expc);
    end
    chk(sat_flag == msat, {tag, " R4 R9 sat flag"}, sat_flag, msat);
  endtask

  task automatic ld(input int r, input int e, input logic [15:0] v);
    @(negedge clk);
    ld_en = 1'b1; ld_reg = 3'(r); ld_elem = 4'(e); ld_data = v;
    @(negedge clk);
    ld_en = 1'b0;
    mdl[r][e] = v;
  endtask

  task automatic expect_reg(input int r, input string tag);
    exp_t it;
    for (int e = 0; e < MVL; e++) begin
      it.r = r; it.e = e; it.v = mdl[r][e]; it.tag = tag;
      sb.push_back(it);
    end
  endtask

  // monitor: drain the scoreboard through the readback port
  task automatic drain();
    exp_t it;
    while (sb.size() > 0) begin
      it = sb.pop_front();
      rb_reg = 3'(it.r); rb_elem = 4'(it.e);
      #1;
      chk(rb_data == it.v, $sformatf("%s v%0d[%0d]", it.tag, it.r, it.e),
          rb_data, it.v);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] seed;
    int cyc;
    for (int r = 0; r < NR; r++)
      for (int e = 0; e < MVL; e++) mdl[r][e] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b1, "R12 done after reset", done, 1);
    chk(sat_flag == 1'b0, "R12 sat after reset", sat_flag, 0);
    chk(cur_vl == 5'd16, "R12 vl after reset", cur_vl, 16);
    expect_reg(3, "R12 reset contents");
    drain();

    // operands, with extreme values at the front
    seed = 16'h1D3F;
    for (int e = 0; e < MVL; e++) begin
      seed = seed * 16'd25173 + 16'd13849;
      ld(1, e, seed);
      seed = seed * 16'd25173 + 16'd13849;
      ld(2, e, seed);
      ld(0, e, (e % 3 != 0) ? 16'h0001 : 16'h0002);
    end
    ld(1, 0, 16'h7FFF); ld(2, 0, 16'h0001);
    ld(1, 1, 16'h8000); ld(2, 1, 16'h0001);
    ld(1, 2, 16'h8000); ld(2, 2, 16'h0013);
    ld(1, 3, 16'hFFF0); ld(2, 3, 16'h0002);
    expect_reg(1, "R11 load v1");
    expect_reg(2, "R11 load v2");
    drain();

    issue(9, 0, 0, 0, 0, 16, "R1 setvl 16");
    chk(cur_vl == 5'd16, "R1 vl=16", cur_vl, 16);
    issue(0, 3, 1, 2, 0, 0, "R2 add");
    expect_reg(3, "R2 add"); drain();
    issue(9, 0, 0, 0, 0, 7, "R1 setvl 7");
    issue(1, 4, 1, 2, 0, 0, "R1 sub vl7");
    expect_reg(4, "R1 sub tail kept"); drain();
    issue(9, 0, 0, 0, 0, 16, "R1 setvl 16");
    issue(2, 5, 1, 2, 0, 0, "R2 min");
    issue(3, 6, 1, 2, 0, 0, "R2 max");
    expect_reg(5, "R2 min"); expect_reg(6, "R2 max"); drain();
    issue(4, 7, 1, 2, 0, 0, "R3 abs");
    expect_reg(7, "R3 abs"); drain();
    chk(sat_flag == 1'b1, "R3 abs sat raised", sat_flag, 1);
    issue(6, 7, 1, 2, 0, 0, "R4 ssub");
    expect_reg(7, "R4 ssub"); drain();
    issue(10, 0, 0, 0, 0, 0, "R9 clear");
    chk(sat_flag == 1'b0, "R9 cleared", sat_flag, 0);
    issue(5, 3, 1, 2, 0, 0, "R4 sadd");
    expect_reg(3, "R4 sadd"); drain();
    chk(sat_flag == 1'b1, "R4 sadd sat raised", sat_flag, 1);
    issue(7, 4, 1, 2, 0, 0, "R5 sra");
    expect_reg(4, "R5 sra"); drain();
    issue(8, 5, 1, 2, 0, 0, "R6 mul vl16");
    expect_reg(5, "R6 mul vl16"); drain();
    issue(9, 0, 0, 0, 0, 5, "R1 setvl 5");
    issue(8, 6, 2, 1, 0, 0, "R6 mul vl5");
    expect_reg(6, "R6 mul vl5"); drain();
    issue(9, 0, 0, 0, 0, 20, "R1 setvl clamp");
    chk(cur_vl == 5'd16, "R1 clamp to MVL", cur_vl, 16);
    issue(9, 0, 0, 0, 0, 0, "R1 setvl 0");
    issue(0, 7, 1, 2, 0, 0, "R1 vl0 add");
    expect_reg(7, "R1 vl0 no write"); drain();
    issue(9, 0, 0, 0, 0, 16, "R1 setvl 16");
    issue(0, 3, 2, 1, 1, 0, "R10 masked add");
    expect_reg(3, "R10 masked add"); drain();

    // R8 / R11: poke while a multiply is running
    @(negedge clk);
    in_valid = 1'b1; in_op = 4'd8; in_vd = 3'd5; in_va = 3'd2; in_vb = 3'd2;
    in_masked = 1'b0;
    @(negedge clk);
    in_op = 4'd0; in_vd = 3'd6; in_va = 3'd1; in_vb = 3'd1;
    ld_en = 1'b1; ld_reg = 3'd5; ld_elem = 4'd0; ld_data = 16'hABCD;
    @(negedge clk);
    in_valid = 1'b0; ld_en = 1'b0;
    cyc = 2;
    while (!done && cyc < 100) begin cyc++; @(negedge clk); end
    chk(cyc == 9, "R8 busy unaffected by poke", cyc, 9);
    for (int e = 0; e < MVL; e++) begin
      bit s;
      mdl[5][e] = model_op(8, mdl[2][e], mdl[2][e], s);
    end
    expect_reg(5, "R11 load ignored while busy");
    expect_reg(6, "R8 valid ignored while busy");
    drain();
    chk(in_ready == done, "R8 ready equals done", in_ready, done);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule